// File: doc/BRIEF.md
# Interrupt Control Unit for a 4-bit Microcontroller

This unit sits beside a small 4-bit processor core. It decides when the core must take an interrupt. It serves four sources: external pin 0, timer 1, timer 2 and the A/D converter. Each source raises a one-cycle request pulse, and the unit latches that pulse in a request flag. A source can interrupt the core only when three things hold together: the global interrupt-enable flag is set, the source's enable bit is set, and its request flag is set. Once those three conditions hold, the unit waits a fixed delay and then pulses `irq_o` with a 2-bit source code. The delay is two machine cycles when the instruction running at that moment takes one cycle, and three when it takes more than one.

The enable bits live in two 4-bit registers. The core loads them from its accumulator with one-cycle write strobes and reads them back on two output buses. Some bits in these registers have no function, but they still store whatever was written. A source's enable bit also decides how that source's software polling instruction behaves. With the bit clear, the polling instruction works and clears the flag. With the bit set, the instruction acts as a no-op. One clock of `clk` is one machine cycle.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: Synchronous reset sets both enable registers to 0000 and clears the request flags, the global enable flag and `irq_o`. A `backup_i` pulse also sets both enable registers to 0000.
- R2: A `wr_v1_i` or `wr_v2_i` strobe copies all four bits of `acc_i` into that register. The new value shows on `v1_o` or `v2_o` on the next cycle, and the other register does not change.
- R3: The bits with no function are `v1_o[1]`, `v2_o[0]`, `v2_o[1]` and `v2_o[3]`. They are stored and read back, but they have no effect on `skip_ok_o` and no effect on interrupts.
- R4: Source bit order on `req_i`, `poll_i`, `req_flag_o` and `skip_ok_o` is: bit 0 external 0, bit 1 timer 1, bit 2 timer 2, bit 3 A/D. The enable bits for these sources are, in the same order, `v1_o[0]`, `v1_o[2]`, `v1_o[3]` and `v2_o[2]`. Each `skip_ok_o` bit is the inverse of its source's enable bit.
- R5: A `req_i` pulse sets its request flag on the next cycle. The flag stays set until that source is accepted, or until a `poll_i` strobe clears it. A `poll_i` strobe clears the flag only while that source's `skip_ok_o` bit is 1; otherwise the strobe is ignored.
- R6: `irq_o` fires only for a source whose global enable flag, enable bit and request flag were all 1.
- R7: Let cycle t be the first cycle in which the three conditions hold. If `multi_cyc_i` is 0 in cycle t, `irq_o` is high for exactly one cycle, in cycle t+2.
- R8: If `multi_cyc_i` is 1 in cycle t, `irq_o` is high in cycle t+3 instead.
- R9: When several sources are ready at once, the priority order is external 0, timer 1, timer 2, A/D. During the `irq_o` pulse, `irq_src_o` gives the code of the accepted source: 0, 1, 2 or 3 respectively.
- R10: Acceptance clears the accepted source's request flag and the global enable flag. Other request flags are kept. A `req_i` pulse on the same cycle as the clear leaves the flag set.
- R11: If the global enable flag or the source's enable bit drops before the delay ends, no interrupt is raised. The request flag stays set and can interrupt later.
- R12: `inte_set_i` sets the global enable flag. `inte_clr_i` clears it, and so does acceptance. When a clear and a set arrive on the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one machine cycle |
| rst | input | 1 | Synchronous active-high reset |
| backup_i | input | 1 | Entry into RAM back-up; clears both enable registers |
| acc_i | input | 4 | Accumulator value for register writes |
| wr_v1_i | input | 1 | Write strobe for enable register 1 |
| wr_v2_i | input | 1 | Write strobe for enable register 2 |
| inte_set_i | input | 1 | Sets the global interrupt-enable flag |
| inte_clr_i | input | 1 | Clears the global interrupt-enable flag |
| multi_cyc_i | input | 1 | The current instruction takes more than one cycle |
| req_i | input | 4 | Request pulses, one per source |
| poll_i | input | 4 | Polling instruction strobes, one per source |
| v1_o | output | 4 | Read-back of enable register 1 |
| v2_o | output | 4 | Read-back of enable register 2 |
| inte_o | output | 1 | Global interrupt-enable flag |
| req_flag_o | output | 4 | Latched request flags |
| skip_ok_o | output | 4 | Polling instruction is valid, one bit per source |
| irq_o | output | 1 | One-cycle interrupt pulse to the core |
| irq_src_o | output | 2 | Code of the accepted source, valid with `irq_o` |

## Verification
The assertions take several things for granted about the core's inputs:
- The global-enable strobes and write strobes are single-cycle pulses.
- `multi_cyc_i` is meaningful in every cycle.
- Reset is held for at least one clock edge before checking starts.

The bench drives every input on the falling clock edge and returns each strobe to zero after one cycle. It holds `multi_cyc_i` steady across the cycle in which the three conditions first hold, so the delay being tested is well defined. It changes the global enable flag or the enable registers only at chosen points relative to a request: a cancellation test drops the flag partway through the delay.

// File: rtl/mcu_irq_pkg.sv
package mcu_irq_pkg;

  // number of interrupt sources served by the unit
  localparam int NSRC = 4;

  // source codes, listed from highest to lowest priority
  typedef enum logic [1:0] {
    SRC_EXT0 = 2'd0,
    SRC_TMR1 = 2'd1,
    SRC_TMR2 = 2'd2,
    SRC_ADC  = 2'd3
  } src_e;

  // position of each enable bit inside its register
  localparam int EN_EXT0_BIT = 0;  // register 1
  localparam int EN_TMR1_BIT = 2;  // register 1
  localparam int EN_TMR2_BIT = 3;  // register 1
  localparam int EN_ADC_BIT  = 2;  // register 2

  // returns the lowest-numbered active source
  function automatic src_e pick_src(input logic [NSRC-1:0] m);
    src_e s;
    s = SRC_EXT0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) s = src_e'(2'(i));
    end
    return s;
  endfunction

endpackage

// File: rtl/mcu_irq_vregs.sv
module mcu_irq_vregs
  import mcu_irq_pkg::*;
#(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             backup_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             wr1_i,
  input  logic             wr2_i,
  output logic [ACC_W-1:0] v1_q,
  output logic [ACC_W-1:0] v2_q,
  output logic [NSRC-1:0]  en_mask
);

  // Every bit is stored, including the bits that have no function.
  always_ff @(posedge clk) begin
    if (rst || backup_i) begin
      v1_q <= '0;
      v2_q <= '0;
    end else begin
      if (wr1_i) v1_q <= acc_i;
      if (wr2_i) v2_q <= acc_i;
    end
  end

  // Gather the enable bits into source order.
  assign en_mask = {v2_q[EN_ADC_BIT], v1_q[EN_TMR2_BIT],
                    v1_q[EN_TMR1_BIT], v1_q[EN_EXT0_BIT]};

  // R1: reset and back-up both clear the registers
  assert_clear_R1: assert property (@(posedge clk)
    (rst || backup_i) |=> (v1_q == '0 && v2_q == '0));

  // R2: without a write strobe, a register keeps its value
  assert_hold_v1_R2: assert property (@(posedge clk) disable iff (rst)
    (!backup_i && !wr1_i) |=> $stable(v1_q));
  assert_hold_v2_R2: assert property (@(posedge clk) disable iff (rst)
    (!backup_i && !wr2_i) |=> $stable(v2_q));

endmodule

// File: rtl/mcu_irq_flags.sv
module mcu_irq_flags
  import mcu_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_q
);

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    // A new request wins over a clear on the same edge.
    always_ff @(posedge clk) begin
      if (rst)           flag_q[g] <= 1'b0;
      else if (req_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end

    // R5 / R10: a request pulse always leaves the flag set
    assert_req_latch_R5: assert property (@(posedge clk) disable iff (rst)
      req_i[g] |=> flag_q[g]);

    // R5: a set flag stays set unless something clears it
    assert_flag_keep_R5: assert property (@(posedge clk) disable iff (rst)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
  end

endmodule

// File: rtl/mcu_irq_seq.sv
module mcu_irq_seq
  import mcu_irq_pkg::*;
#(
  parameter int LAT_SHORT = 2,
  parameter int LAT_LONG  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inte_set_i,
  input  logic            inte_clr_i,
  input  logic            multi_cyc_i,
  input  logic [NSRC-1:0] en_mask,
  input  logic [NSRC-1:0] flag_q,
  output logic            inte_q,
  output logic            irq_q,
  output logic [1:0]      src_q,
  output logic [NSRC-1:0] accept
);

  localparam int CW = $clog2(LAT_LONG + 1);

  logic [NSRC-1:0] live;
  logic            cond;
  logic            pend_q;
  logic [CW-1:0]   cnt_q;
  logic            fire;
  src_e            win;

  // a source is live when its flag, its enable bit and the global flag are all set
  assign live   = en_mask & flag_q & {NSRC{inte_q}};
  assign cond   = |live;
  assign win    = pick_src(live);
  assign fire   = pend_q && cond && (cnt_q == CW'(1));
  assign accept = fire ? (NSRC'(1) << win) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      inte_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      src_q  <= '0;
    end else begin
      irq_q <= fire;
      if (fire) src_q <= win;

      if (inte_clr_i || fire) inte_q <= 1'b0;
      else if (inte_set_i)    inte_q <= 1'b1;

      if (fire || !cond) begin
        pend_q <= 1'b0;
      end else if (!pend_q) begin
        // first cycle with all conditions: load the delay
        pend_q <= 1'b1;
        cnt_q  <= multi_cyc_i ? CW'(LAT_LONG - 1) : CW'(LAT_SHORT - 1);
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  // R7: the interrupt is a single-cycle pulse
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R10: the global flag is already clear while the pulse is high
  assert_inte_drop_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !inte_q);

  // R6: a pulse needs the global flag set in the cycle before it
  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(inte_q));

  // R11: a wait whose conditions have lapsed raises no interrupt
  assert_cancel_R11: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !cond) |=> !irq_q);

  // R12: a clear strobe always wins over a set strobe
  assert_clr_wins_R12: assert property (@(posedge clk) disable iff (rst)
    inte_clr_i |=> !inte_q);

endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import mcu_irq_pkg::*;
#(
  parameter int ACC_W     = 4,
  parameter int LAT_SHORT = 2,
  parameter int LAT_LONG  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             backup_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             wr_v1_i,
  input  logic             wr_v2_i,
  input  logic             inte_set_i,
  input  logic             inte_clr_i,
  input  logic             multi_cyc_i,
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  poll_i,
  output logic [ACC_W-1:0] v1_o,
  output logic [ACC_W-1:0] v2_o,
  output logic             inte_o,
  output logic [NSRC-1:0]  req_flag_o,
  output logic [NSRC-1:0]  skip_ok_o,
  output logic             irq_o,
  output logic [1:0]       irq_src_o
);

  logic [NSRC-1:0] en_mask;
  logic [NSRC-1:0] accept;
  logic [NSRC-1:0] clr_mask;

  mcu_irq_vregs #(.ACC_W(ACC_W)) u_vregs (
    .clk      (clk),
    .rst      (rst),
    .backup_i (backup_i),
    .acc_i    (acc_i),
    .wr1_i    (wr_v1_i),
    .wr2_i    (wr_v2_i),
    .v1_q     (v1_o),
    .v2_q     (v2_o),
    .en_mask  (en_mask)
  );

  // a polling instruction is valid only while its source is disabled
  assign skip_ok_o = ~en_mask;
  assign clr_mask  = accept | (poll_i & skip_ok_o);

  mcu_irq_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .clr_i  (clr_mask),
    .flag_q (req_flag_o)
  );

  mcu_irq_seq #(
    .LAT_SHORT (LAT_SHORT),
    .LAT_LONG  (LAT_LONG)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .inte_set_i  (inte_set_i),
    .inte_clr_i  (inte_clr_i),
    .multi_cyc_i (multi_cyc_i),
    .en_mask     (en_mask),
    .flag_q      (req_flag_o),
    .inte_q      (inte_o),
    .irq_q       (irq_o),
    .src_q       (irq_src_o),
    .accept      (accept)
  );

  // R5: an invalid polling strobe leaves the flag alone
  assert_poll_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (req_flag_o[0] && poll_i[0] && !skip_ok_o[0] && !accept[0]) |=> req_flag_o[0]);

endmodule

// File: tb/mcu_irq_ctrl_tb.sv
module mcu_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst, backup_i, wr_v1_i, wr_v2_i, inte_set_i, inte_clr_i, multi_cyc_i;
  logic [3:0] acc_i, req_i, poll_i;
  logic [3:0] v1_o, v2_o, req_flag_o, skip_ok_o;
  logic       inte_o, irq_o;
  logic [1:0] irq_src_o;

  always #10 clk = ~clk;  // 50 MHz

  mcu_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .backup_i(backup_i), .acc_i(acc_i),
    .wr_v1_i(wr_v1_i), .wr_v2_i(wr_v2_i), .inte_set_i(inte_set_i),
    .inte_clr_i(inte_clr_i), .multi_cyc_i(multi_cyc_i), .req_i(req_i),
    .poll_i(poll_i), .v1_o(v1_o), .v2_o(v2_o), .inte_o(inte_o),
    .req_flag_o(req_flag_o), .skip_ok_o(skip_ok_o), .irq_o(irq_o),
    .irq_src_o(irq_src_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int    at;
    int    src;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_irq(int at, int src, string tag);
    exp_t e;
    e.at = at; e.src = src; e.tag = tag;
    sb.push_back(e);
  endtask

  // scoreboard monitor: samples shortly after each rising edge
  always begin
    exp_t e;
    @(posedge clk);
    #2;
    if (!rst) begin
      if (irq_o) begin
        if (sb.size() == 0) chk("R6 unexpected irq at cycle", cyc, -1);
        else begin
          e = sb.pop_front();
          chk({e.tag, " irq cycle"}, cyc, e.at);
          chk({e.tag, " R9 irq source"}, int'(irq_src_o), e.src);
        end
      end else if (sb.size() > 0 && sb[0].at < cyc) begin
        e = sb.pop_front();
        chk({e.tag, " missing irq, cycle"}, -1, e.at);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(int which, logic [3:0] v);
    acc_i = v;
    if (which == 1) wr_v1_i = 1'b1; else wr_v2_i = 1'b1;
    tick();
    wr_v1_i = 1'b0; wr_v2_i = 1'b0;
  endtask

  task automatic pulse_req(logic [3:0] m);
    req_i = m; tick(); req_i = '0;
  endtask

  task automatic set_inte();
    inte_set_i = 1'b1; tick(); inte_set_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; backup_i = 0; acc_i = '0; wr_v1_i = 0; wr_v2_i = 0;
    inte_set_i = 0; inte_clr_i = 0; multi_cyc_i = 0; req_i = '0; poll_i = '0;
    repeat (3) tick();
    chk("R1 v1 at reset", v1_o, 0);
    chk("R1 v2 at reset", v2_o, 0);
    chk("R1 inte at reset", inte_o, 0);
    chk("R1 flags at reset", req_flag_o, 0);
    chk("R1 irq at reset", irq_o, 0);
    chk("R4 skip_ok at reset", skip_ok_o, 4'b1111);
    rst = 1'b0;
    tick();

    // R2 / R4: write and read back, skip bits follow the enable bits
    wr(1, 4'b1010);
    chk("R2 v1 readback", v1_o, 4'b1010);
    chk("R4 skip_ok with timer2 enabled", skip_ok_o, 4'b1011);
    wr(2, 4'b1011);
    chk("R2 v2 readback", v2_o, 4'b1011);
    chk("R2 v1 untouched by v2 write", v1_o, 4'b1010);
    chk("R3 v2 spare bits leave skip_ok", skip_ok_o, 4'b1011);

    // R3: only spare bits set, all sources requesting, global flag on
    wr(1, 4'b0010);
    set_inte();
    chk("R12 inte set", inte_o, 1);
    pulse_req(4'b1111);
    repeat (6) tick();
    chk("R5 all flags latched", req_flag_o, 4'b1111);
    chk("R3 spare bits leave skip_ok", skip_ok_o, 4'b1111);

    // R5: valid polling clears flags
    poll_i = 4'b0011; tick(); poll_i = '0;
    chk("R5 valid poll clears", req_flag_o, 4'b1100);
    inte_clr_i = 1'b1; tick(); inte_clr_i = 1'b0;
    wr(1, 4'b1000);
    poll_i = 4'b0100; tick(); poll_i = '0;
    chk("R5 invalid poll ignored", req_flag_o, 4'b1100);
    wr(1, 4'b0000);
    poll_i = 4'b1100; tick(); poll_i = '0;
    chk("R5 remaining flags polled", req_flag_o, 4'b0000);

    // R7: one-cycle instruction, delay 2
    wr(2, 4'b0000);
    wr(1, 4'b0001);
    set_inte();
    expect_irq(cyc + 3, 0, "R7");
    pulse_req(4'b0001);
    repeat (5) tick();
    chk("R10 inte cleared on accept", inte_o, 0);
    chk("R10 flag cleared on accept", req_flag_o, 0);

    // R8: multi-cycle instruction, delay 3
    set_inte();
    multi_cyc_i = 1'b1;
    expect_irq(cyc + 4, 0, "R8");
    pulse_req(4'b0001);
    tick();
    multi_cyc_i = 1'b0;
    repeat (5) tick();

    // R9 / R10: priority among four pending sources
    wr(1, 4'b1101);
    wr(2, 4'b0100);
    pulse_req(4'b1111);
    tick();
    expect_irq(cyc + 3, 0, "R9");
    set_inte();
    tick();
    req_i = 4'b0001;  // arrives on the accepting edge
    tick();
    req_i = '0;
    chk("R10 request on clear cycle kept", req_flag_o, 4'b1111);
    chk("R10 inte after accept", inte_o, 0);
    repeat (2) tick();
    for (int s = 0; s < 4; s++) begin
      expect_irq(cyc + 3, s, "R9");
      set_inte();
      repeat (4) tick();
    end
    chk("R9 all sources served", req_flag_o, 0);

    // R11: global flag dropped during the delay
    wr(2, 4'b0000);
    wr(1, 4'b0001);
    set_inte();
    multi_cyc_i = 1'b1;
    req_i = 4'b0001;
    tick();
    req_i = '0;
    inte_clr_i = 1'b1;
    tick();
    inte_clr_i = 1'b0;
    multi_cyc_i = 1'b0;
    repeat (5) tick();
    chk("R11 flag kept after cancel", req_flag_o, 4'b0001);
    chk("R11 inte cleared", inte_o, 0);

    // R12: clear wins over set
    inte_set_i = 1'b1; inte_clr_i = 1'b1; tick();
    inte_set_i = 1'b0; inte_clr_i = 1'b0;
    chk("R12 clear wins", inte_o, 0);
    repeat (3) tick();

    // R11: the kept flag interrupts once re-enabled
    expect_irq(cyc + 3, 0, "R11");
    set_inte();
    repeat (4) tick();

    // R1: back-up clears the enable registers
    wr(2, 4'b1111);
    backup_i = 1'b1; tick(); backup_i = 1'b0;
    chk("R1 v1 after backup", v1_o, 0);
    chk("R1 v2 after backup", v2_o, 0);

    repeat (3) tick();
    chk("R6 scoreboard drained", sb.size(), 0);
    finish_run();
  end

endmodule